// File: doc/BRIEF.md
# Bidirectional Interleaved Column Shift Driver

This block is the logic core of a 64-column display driver. Pixel data enter serially, four bits per shift clock, into four interleaved 16-stage chains. Chain c (c = 0..3) owns the stages numbered c+1, c+5, c+9 and onward up to c+61, so together the chains fill all 64 stages. A direction select chooses which end of the chains takes data in and which end passes data on. The ports on the far end feed the next device in a cascade. When a row is fully loaded, a latch captures all 64 stages on a rising clock edge. A combined blank and polarity stage then drives the 64 column outputs.

The shift chains advance on the falling edge of the shift clock. The latch samples on the rising edge. This lets the controller load the next row while the current row is displayed. Each end port is modelled as a pad with separate in, out and output-enable signals. Data arrive on the ports at the shift clock's own rate, with no handshake. The block cannot stall, so a stream source must present a new nibble for every falling edge it wants consumed. Flow control is done by gating the clock upstream.

Top module: `disp_col_driver`

## Requirements
- R1: An active-low asynchronous reset clears all 64 stages and the latch to zero. During reset both end ports read zero. With blank low and polarity high, all 64 outputs read zero.
- R2: Stage k (1..64) belongs to chain (k-1) mod 4. One shift moves each bit from stage k to stage k+4 (right) or to stage k-4 (left). A single bit entered on port 1 of the A end lands in output bit 0 after one shift and in output bit 4 after a second shift.
- R3: Stages change only on a falling edge of the shift clock. The end-port outputs stay unchanged across a rising edge.
- R4: With direction high (right), A-port bit c loads stage c+1 on each falling edge. B-port bit c shows stage 61+c. B output-enables are all high and A output-enables are all low.
- R5: With direction low (left), B-port bit c loads stage 61+c on each falling edge. A-port bit c shows stage c+1. A output-enables are all high and B output-enables are all low.
- R6: On a rising edge while latch enable is high, the latch takes a copy of all 64 stages. Output bit k-1 corresponds to stage k.
- R7: While latch enable is low, rising edges leave the latch and the outputs unchanged, even as the stages shift.
- R8: With blank high, all 64 outputs equal the polarity input.
- R9: With blank low, the outputs equal the latch bits when polarity is high, and the inverted latch bits when polarity is low.
- R10: In right-shift mode, a bit placed on A-port c at one falling edge appears on B-port c after exactly 16 falling edges. This is the cascade latency between chained devices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sh | input | 1 | Shift clock; falling edge shifts, rising edge latches |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_right | input | 1 | 1: data flow A to B; 0: data flow B to A |
| latch_en | input | 1 | Qualifies latch capture on the rising edge |
| blank | input | 1 | Forces every output to the polarity level |
| pol | input | 1 | 1: true outputs; 0: inverted outputs |
| a_in | input | 4 | A-end pad inputs, one per chain |
| a_out | output | 4 | A-end pad outputs (stages 1..4) |
| a_oe | output | 4 | A-end pad output enables |
| b_in | input | 4 | B-end pad inputs, one per chain |
| b_out | output | 4 | B-end pad outputs (stages 61..64) |
| b_oe | output | 4 | B-end pad output enables |
| drv | output | 64 | Column driver outputs, bit k-1 for stage k |

## Verification
A wrong stage bit is visible in two places. It reaches the output-side end port after at most 16 further falling edges in the current direction. It reaches the column outputs after the next rising edge with latch enable high. The bench therefore compares the end port after every shift, and the full 64-bit output after every latch, against a behavioural model. This catches a misrouted chain or a swapped direction within one clock. A latch that ignores its enable shows as changed outputs one rising edge after a shift. Blank and polarity faults show immediately, because that stage is combinational.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic {
    SHIFT_LEFT  = 1'b0,
    SHIFT_RIGHT = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/disp_shift_chain.sv
module disp_shift_chain #(
  parameter int LEN = 16
) (
  input  logic           clk_sh,
  input  logic           rst_n,
  input  logic           dir_right,
  input  logic           head_in,
  input  logic           tail_in,
  output logic [LEN-1:0] stg
);
  import disp_pkg::*;

  shift_dir_e dir_e;
  logic       seen_q;

  assign dir_e = shift_dir_e'(dir_right);

  always_ff @(negedge clk_sh or negedge rst_n) begin
    if (!rst_n) begin
      stg    <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (dir_e == SHIFT_RIGHT) stg <= {stg[LEN-2:0], head_in};
      else                      stg <= {tail_in, stg[LEN-1:1]};
    end
  end

  assert_right_entry_R4: assert property (@(negedge clk_sh) disable iff (!rst_n)
    ($past(seen_q) && $past(dir_right)) |-> (stg[0] == $past(head_in)));

  assert_left_entry_R5: assert property (@(negedge clk_sh) disable iff (!rst_n)
    ($past(seen_q) && !$past(dir_right)) |-> (stg[LEN-1] == $past(tail_in)));

  assert_shift_carry_R2: assert property (@(negedge clk_sh) disable iff (!rst_n)
    ($past(seen_q) && $past(dir_right)) |-> (stg[LEN-1:1] == $past(stg[LEN-2:0])));
endmodule

// File: rtl/disp_latch.sv
module disp_latch #(
  parameter int W = 64
) (
  input  logic         clk_sh,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic seen_q;

  always_ff @(posedge clk_sh or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (load_en) q <= d;
    end
  end

  assert_latch_load_R6: assert property (@(posedge clk_sh) disable iff (!rst_n)
    ($past(seen_q) && $past(load_en)) |-> (q == $past(d)));

  assert_latch_hold_R7: assert property (@(posedge clk_sh) disable iff (!rst_n)
    ($past(seen_q) && !$past(load_en)) |-> $stable(q));
endmodule

// File: rtl/disp_out_stage.sv
module disp_out_stage #(
  parameter int W = 64
) (
  input  logic         blank,
  input  logic         pol,
  input  logic [W-1:0] lat,
  output logic [W-1:0] drv
);
  always_comb begin
    if (blank) drv = {W{pol}};
    else       drv = lat ^ {W{~pol}};
  end
endmodule

// File: rtl/disp_col_driver.sv
module disp_col_driver #(
  parameter int NCHAIN = 4,
  parameter int CLEN   = 16
) (
  input  logic                   clk_sh,
  input  logic                   rst_n,
  input  logic                   dir_right,
  input  logic                   latch_en,
  input  logic                   blank,
  input  logic                   pol,
  input  logic [NCHAIN-1:0]      a_in,
  output logic [NCHAIN-1:0]      a_out,
  output logic [NCHAIN-1:0]      a_oe,
  input  logic [NCHAIN-1:0]      b_in,
  output logic [NCHAIN-1:0]      b_out,
  output logic [NCHAIN-1:0]      b_oe,
  output logic [NCHAIN*CLEN-1:0] drv
);
  localparam int W = NCHAIN * CLEN;

  logic [CLEN-1:0] chain_stg [NCHAIN];
  logic [W-1:0]    stages;
  logic [W-1:0]    lat_q;

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    disp_shift_chain #(.LEN(CLEN)) u_chain (
      .clk_sh   (clk_sh),
      .rst_n    (rst_n),
      .dir_right(dir_right),
      .head_in  (a_in[c]),
      .tail_in  (b_in[c]),
      .stg      (chain_stg[c])
    );
    assign a_out[c] = chain_stg[c][0];
    assign b_out[c] = chain_stg[c][CLEN-1];
    for (genvar p = 0; p < CLEN; p++) begin : g_pos
      assign stages[p*NCHAIN + c] = chain_stg[c][p];
    end
  end

  assign a_oe = {NCHAIN{~dir_right}};
  assign b_oe = {NCHAIN{dir_right}};

  disp_latch #(.W(W)) u_latch (
    .clk_sh (clk_sh),
    .rst_n  (rst_n),
    .load_en(latch_en),
    .d      (stages),
    .q      (lat_q)
  );

  disp_out_stage #(.W(W)) u_out (
    .blank(blank),
    .pol  (pol),
    .lat  (lat_q),
    .drv  (drv)
  );

  always_comb begin
    if (rst_n && blank) assert_blank_level_R8: assert (drv == {W{pol}});
  end
endmodule

// File: tb/disp_col_driver_tb.sv
module disp_col_driver_tb;
  logic        clk_sh = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_right = 1'b1, latch_en = 1'b0, blank = 1'b0, pol = 1'b1;
  logic [3:0]  a_in = '0, b_in = '0;
  logic [3:0]  a_out, a_oe, b_out, b_oe;
  logic [63:0] drv;

  int n_chk = 0, n_fail = 0;
  logic [63:0] ref_q = '0;
  logic [63:0] ref_lat = '0;

  // vector: {dir_right, blank, pol, seed[15:0]}
  localparam logic [18:0] VECS [0:5] = '{
    {1'b1, 1'b0, 1'b1, 16'hA5C3},
    {1'b0, 1'b0, 1'b1, 16'h3C96},
    {1'b1, 1'b0, 1'b0, 16'h1F0E},
    {1'b0, 1'b1, 1'b1, 16'h7777},
    {1'b1, 1'b1, 1'b0, 16'hBEEF},
    {1'b0, 1'b0, 1'b0, 16'h0FF1}
  };

  disp_col_driver u_dut (
    .clk_sh(clk_sh), .rst_n(rst_n), .dir_right(dir_right), .latch_en(latch_en),
    .blank(blank), .pol(pol), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .drv(drv)
  );

  always #5 clk_sh = ~clk_sh;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_drv(input logic [63:0] l, input logic bl, input logic p);
    return bl ? {64{p}} : (p ? l : ~l);
  endfunction

  // one falling edge then one rising edge; inputs already set
  task automatic step(input logic chk_ports);
    logic [3:0] held;
    @(negedge clk_sh); #1;
    if (dir_right) ref_q = {ref_q[59:0], a_in};
    else           ref_q = {b_in, ref_q[63:4]};
    if (chk_ports) begin
      if (dir_right) begin
        chk("R4 b_out", 64'(b_out), 64'(ref_q[63:60]));
        chk("R4 oe", {56'd0, a_oe, b_oe}, {56'd0, 4'h0, 4'hF});
      end else begin
        chk("R5 a_out", 64'(a_out), 64'(ref_q[3:0]));
        chk("R5 oe", {56'd0, a_oe, b_oe}, {56'd0, 4'hF, 4'h0});
      end
    end
    held = dir_right ? b_out : a_out;
    @(posedge clk_sh); #1;
    if (latch_en) ref_lat = ref_q;
    if (chk_ports) chk("R3 hold across rise", 64'(dir_right ? b_out : a_out), 64'(held));
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #22;
    // R1 reset state
    chk("R1 drv", drv, 64'd0);
    chk("R1 ports", {56'd0, a_out, b_out}, 64'd0);
    @(posedge clk_sh); #1;
    rst_n = 1'b1;

    // R2 interleave: single bit into chain 0
    latch_en = 1'b1; dir_right = 1'b1; a_in = 4'b0001;
    step(1'b0);
    chk("R2 first shift", drv, 64'h1);
    a_in = 4'b0000;
    step(1'b0);
    chk("R2 second shift", drv, 64'h10);

    // main table
    for (int v = 0; v < 6; v++) begin
      logic [3:0] first_nib;
      dir_right = VECS[v][18];
      latch_en  = 1'b1;
      blank     = 1'b0;
      pol       = 1'b1;
      first_nib = '0;
      for (int i = 0; i < 16; i++) begin
        logic [3:0] nib;
        nib = VECS[v][(i%4)*4 +: 4] ^ 4'(i);
        if (i == 0) first_nib = nib;
        a_in = dir_right ? nib : 4'h0;
        b_in = dir_right ? 4'h0 : nib;
        step(1'b1);
        if (dir_right && i == 15) chk("R10 cascade latency", 64'(b_out), 64'(first_nib));
      end
      chk("R6 latch row", drv, ref_q);
      blank = VECS[v][17];
      pol   = VECS[v][16];
      #1;
      chk(blank ? "R8 blank level" : "R9 polarity", drv, exp_drv(ref_lat, blank, pol));
    end

    // R7: latch enable low holds outputs while stages move
    blank = 1'b0; pol = 1'b1; latch_en = 1'b0; dir_right = 1'b1;
    for (int i = 0; i < 3; i++) begin
      a_in = 4'(4'hA + i);
      step(1'b0);
      chk("R7 hold", drv, ref_lat);
    end
    latch_en = 1'b1;
    step(1'b0);
    chk("R6 reload", drv, ref_q);
    pol = 1'b0; #1;
    chk("R9 invert", drv, ~ref_q);
    blank = 1'b1; #1;
    chk("R8 blank low", drv, 64'd0);
    pol = 1'b1; #1;
    chk("R8 blank high", drv, {64{1'b1}});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule